// File: doc/BRIEF.md
# Abstract Register-Access Instruction Generator

This block turns a debugger's "access register" abstract command into two machine instructions. The hart runs them from a two-word abstract-program area that sits directly below the program buffer. The first word moves a general-purpose register between the hart and the data window, or it is a harmless store of x0 when no transfer is asked for. The second word either jumps into the program buffer or stops with ebreak.

A debug front end pulses `start_i` with the command word and the halted status of the selected hart. One cycle later the block pulses `done_o` and reports an error code.

- **On success:** it updates both instruction words and pulses `go_set_o` and `busy_set_o`. These tell the surrounding logic to raise that hart's GO flag and mark the abstract engine busy.
- **On failure:** the instruction words keep their previous values and neither strobe fires.

Executing the instructions and detecting completion belong to other logic.

Command fields that are decoded:

| Bits | Meaning |
|------|---------|
| [31:24] | command type (0 = access register) |
| [22:20] | size |
| [18] | post-execute |
| [17] | transfer |
| [16] | write |
| [15:0] | register number |

Top module: `absreg_gen`

## Requirements
- R1: After reset, `done_o`, `go_set_o` and `busy_set_o` are 0, `err_o` is 0 and both instruction outputs are 32'h0.
- R2: Every cycle with `start_i` high produces exactly one `done_o` pulse in the following cycle, carrying that command's result.
- R3: A command type other than 0 gives error code 2 (not supported). This check takes precedence over the halted check.
- R4: An access-register command for a hart that is not halted gives error code 4 (halt/resume).
- R5: With transfer set, a register number outside 0x1000..0x101F gives error code 2.
- R6: With transfer set, a size other than 2 or 3 gives error code 2.
- R7: With transfer set and size 2, the first word uses index = register number minus 0x1000 and the data window base (default 0x380) as its 12-bit offset from x0.
  - On a write it is a 32-bit load (opcode 0000011, funct3 010, rd = index).
  - On a read it is a 32-bit store (opcode 0100011, funct3 010, rs2 = index).
- R8: With transfer set and size 3, the first word is built as in R7 but with funct3 011 (64-bit load/store).
- R9: With transfer clear, the first word is a store of x0 to the data window base (funct3 010), whatever the size and register number.
- R10: The second word depends on post-execute.
  - With post-execute set, it is a J-type jump with rd = x0. Its offset is the program buffer start (default 0x340) minus the address of the second abstract word, which is the buffer start minus 4. That gives 32'h0040006F by default.
  - With post-execute clear, it is ebreak (32'h00100073).
- R11: A successful command gives error code 0 and pulses `go_set_o` and `busy_set_o` together with `done_o`.
- R12: A failing command leaves both instruction outputs unchanged and pulses neither `go_set_o` nor `busy_set_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command strobe |
| cmd_i | input | 32 | Abstract command word |
| halted_i | input | 1 | Selected hart is halted |
| insn0_o | output | 32 | First abstract instruction |
| insn1_o | output | 32 | Second abstract instruction |
| done_o | output | 1 | Result valid pulse |
| go_set_o | output | 1 | Set GO flag of selected hart |
| busy_set_o | output | 1 | Set abstract busy |
| err_o | output | 3 | Error code (0, 2 or 4) |

## Verification
The stimulus covers read and write transfers at both legal sizes across the low, middle and top register indices. Comparing these separates load from store, funct3 010 from 011, and correct placement of the rd field against the rs2 field. Transfer-clear commands with deliberately bad sizes and register numbers show that the range and size checks are gated by the transfer bit. Pairing post-execute on and off checks the J-type immediate scrambling against ebreak.

Error commands are issued right after a successful one, so unchanged instruction words show that nothing was generated. A wrong command type on a running hart shows which error has priority. Register numbers 0x0FFF and 0x1020 probe both edges of the legal range.

// File: rtl/absreg_gen.sv
module absreg_gen #(
  parameter logic [11:0] DATA_ADDR = 12'h380,
  parameter logic [11:0] PBUF_ADDR = 12'h340,
  parameter logic [15:0] GPR_BASE  = 16'h1000,
  parameter int unsigned GPR_COUNT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] cmd_i,
  input  logic        halted_i,
  output logic [31:0] insn0_o,
  output logic [31:0] insn1_o,
  output logic        done_o,
  output logic        go_set_o,
  output logic        busy_set_o,
  output logic [2:0]  err_o
);
  localparam logic [11:0] ABS_ADDR = PBUF_ADDR - 12'd8;
  localparam logic [20:0] JMP_OFS  = 21'(PBUF_ADDR - (ABS_ADDR + 12'd4));
  localparam logic [2:0]  E_NONE = 3'd0, E_NOTSUP = 3'd2, E_HALT = 3'd4;
  localparam logic [31:0] EBREAK = 32'h0010_0073;

  wire [7:0]  kind  = cmd_i[31:24];
  wire [2:0]  size  = cmd_i[22:20];
  wire        post  = cmd_i[18];
  wire        xfer  = cmd_i[17];
  wire        wr    = cmd_i[16];
  wire [15:0] regno = cmd_i[15:0];
  wire [15:0] rel   = regno - GPR_BASE;
  wire        in_rng = (regno >= GPR_BASE) && ({16'h0, rel} < GPR_COUNT);
  wire [4:0]  gpr   = rel[4:0];
  wire [2:0]  f3    = (size == 3'd3) ? 3'b011 : 3'b010;

  function automatic logic [31:0] ld_op(input logic [4:0] rd, input logic [2:0] fn);
    return {DATA_ADDR, 5'd0, fn, rd, 7'b0000011};
  endfunction

  function automatic logic [31:0] st_op(input logic [4:0] rs, input logic [2:0] fn);
    return {DATA_ADDR[11:5], rs, 5'd0, fn, DATA_ADDR[4:0], 7'b0100011};
  endfunction

  function automatic logic [31:0] jal_op(input logic [20:0] ofs);
    return {ofs[20], ofs[10:1], ofs[11], ofs[19:12], 5'd0, 7'b1101111};
  endfunction

  logic [2:0]  err_n;
  logic [31:0] i0_n;

  always_comb begin
    if (kind != 8'd0)                                      err_n = E_NOTSUP;
    else if (!halted_i)                                    err_n = E_HALT;
    else if (xfer && (!in_rng || (size != 3'd2 && size != 3'd3))) err_n = E_NOTSUP;
    else                                                   err_n = E_NONE;
  end

  always_comb begin
    if (!xfer)   i0_n = st_op(5'd0, 3'b010);
    else if (wr) i0_n = ld_op(gpr, f3);
    else         i0_n = st_op(gpr, f3);
  end

  wire ok = start_i && (err_n == E_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn0_o    <= '0;
      insn1_o    <= '0;
      done_o     <= 1'b0;
      go_set_o   <= 1'b0;
      busy_set_o <= 1'b0;
      err_o      <= E_NONE;
    end else begin
      done_o     <= start_i;
      go_set_o   <= ok;
      busy_set_o <= ok;
      if (start_i) err_o <= err_n;
      if (ok) begin
        insn0_o <= i0_n;
        insn1_o <= post ? jal_op(JMP_OFS) : EBREAK;
      end
    end
  end
endmodule

module absreg_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [31:0] cmd_i,
  input logic        halted_i,
  input logic [31:0] insn0_o,
  input logic [31:0] insn1_o,
  input logic        done_o,
  input logic        go_set_o,
  input logic        busy_set_o,
  input logic [2:0]  err_o
);
  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  // R11
  go_busy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_set_o |-> (busy_set_o && done_o && err_o == 3'd0));
  // R12
  fail_no_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o != 3'd0) |-> (!go_set_o && $stable(insn0_o) && $stable(insn1_o)));
  // R4
  halt_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cmd_i[31:24] == 8'd0 && !halted_i) |=> (err_o == 3'd4));
  // R3
  kind_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cmd_i[31:24] != 8'd0) |=> (err_o == 3'd2 && !go_set_o));
  // R10
  tail_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_set_o |-> (insn1_o == 32'h0010_0073 || insn1_o[11:0] == 12'h06F));
endmodule

bind absreg_gen absreg_gen_chk u_chk (.*);

// File: tb/sim_absreg_gen.sv
module sim_absreg_gen;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, halted_i = 1'b0;
  logic [31:0] cmd_i = '0;
  logic [31:0] insn0_o, insn1_o;
  logic done_o, go_set_o, busy_set_o;
  logic [2:0] err_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  absreg_gen u0 (.*);

  typedef struct { logic [31:0] i0, i1; logic go; logic [2:0] err; string tag; } exp_t;
  exp_t q[$];
  logic [31:0] last0 = '0, last1 = '0;
  localparam logic [11:0] DB = 12'h380;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  function automatic logic [31:0] mk_cmd(input logic [7:0] k, input logic [2:0] sz,
      input bit post, xfer, wr, input logic [15:0] rn);
    return {k, 1'b0, sz, 1'b0, post, xfer, wr, rn};
  endfunction
  function automatic logic [31:0] e_load(input logic [4:0] rd, input logic [2:0] f);
    return (32'(DB) << 20) | (32'(f) << 12) | (32'(rd) << 7) | 32'h03;
  endfunction
  function automatic logic [31:0] e_store(input logic [4:0] rs, input logic [2:0] f);
    return (32'(DB[11:5]) << 25) | (32'(rs) << 20) | (32'(f) << 12) | (32'(DB[4:0]) << 7) | 32'h23;
  endfunction

  task automatic issue(input logic [31:0] c, input bit h, input logic [31:0] i0, i1,
      input logic [2:0] e, input string tag);
    exp_t x;
    @(negedge clk);
    cmd_i = c; halted_i = h; start_i = 1'b1;
    if (e == 3'd0) begin last0 = i0; last1 = i1; end
    x.i0 = last0; x.i1 = last1; x.go = (e == 3'd0); x.err = e; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done_o) begin
        exp_t x;
        if (q.size() == 0) chk(0, "R2 unexpected done", 32'(done_o), 0);
        else begin
          x = q.pop_front();
          chk(err_o == x.err, {x.tag, " err"}, 32'(err_o), 32'(x.err));
          chk(insn0_o == x.i0, {x.tag, " insn0"}, insn0_o, x.i0);
          chk(insn1_o == x.i1, {x.tag, " insn1"}, insn1_o, x.i1);
          chk(go_set_o == x.go && busy_set_o == x.go, {x.tag, " R11 go/busy"},
              {30'd0, go_set_o, busy_set_o}, {30'd0, x.go, x.go});
        end
      end else if (rst_n && (go_set_o || busy_set_o))
        chk(0, "R11 stray strobe", 32'(go_set_o), 0);
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [31:0] EB = 32'h0010_0073, JMP = 32'h0040_006F;

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!done_o && !go_set_o && !busy_set_o && err_o == 0, "R1 reset strobes",
        {28'd0, done_o, go_set_o, busy_set_o, 1'b0}, 0);
    chk(insn0_o == 0 && insn1_o == 0, "R1 reset insns", insn0_o | insn1_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(mk_cmd(0, 2, 0, 1, 1, 16'h1005), 1, e_load(5, 3'b010), EB, 0, "R7 lw x5");
    chk(e_load(5, 3'b010) == 32'h3800_2283, "R7 literal lw", e_load(5, 3'b010), 32'h3800_2283);
    issue(mk_cmd(0, 2, 1, 1, 0, 16'h1000), 1, e_store(0, 3'b010), JMP, 0, "R7 sw x0 R10 jal");
    issue(mk_cmd(0, 3, 0, 1, 1, 16'h101F), 1, e_load(31, 3'b011), EB, 0, "R8 ld x31");
    issue(mk_cmd(0, 3, 1, 1, 0, 16'h1011), 1, e_store(17, 3'b011), JMP, 0, "R8 sd x17");
    issue(mk_cmd(0, 7, 1, 0, 1, 16'h0042), 1, e_store(0, 3'b010), JMP, 0, "R9 no transfer");
    issue(mk_cmd(0, 2, 0, 1, 1, 16'h1003), 0, 0, 0, 4, "R4 R12 not halted");
    issue(mk_cmd(1, 2, 0, 1, 1, 16'h1003), 0, 0, 0, 2, "R3 R12 kind over halt");
    issue(mk_cmd(0, 2, 0, 1, 1, 16'h0FFF), 1, 0, 0, 2, "R5 below range");
    issue(mk_cmd(0, 2, 0, 1, 1, 16'h1020), 1, 0, 0, 2, "R5 above range");
    issue(mk_cmd(0, 4, 0, 1, 1, 16'h1001), 1, 0, 0, 2, "R6 size 4");
    issue(mk_cmd(0, 1, 0, 1, 0, 16'h1001), 1, 0, 0, 2, "R6 size 1");
    issue(mk_cmd(0, 2, 0, 0, 0, 16'h0000), 1, e_store(0, 3'b010), EB, 0, "R9 R10 ebreak");
    issue(mk_cmd(0, 2, 1, 1, 0, 16'h100A), 1, e_store(10, 3'b010), JMP, 0, "R2 R11 sw x10");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2 all done", 32'(q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule